// File: doc/BRIEF.md
# Receive Channel Code Substitution

This block sits on the byte-wide receive path of a 24-slot time-division frame. Each beat carries one channel's byte, that channel's slot index, and a flag marking the first beat of a frame. For every beat the block either forwards the byte untouched or swaps in a fixed code. It does this when the slot's mark bit is set and insertion is enabled globally. The code is either a constant idle byte or one byte of a repeating µ-law digital milliwatt tone.

The byte path is a valid/ready stream with a single register stage. A beat is accepted in any cycle where `in_valid` and `in_ready` are both high. That beat appears on the output port the following cycle. While `out_valid` is high and `out_ready` is low, the output beat is held frozen and `in_ready` stays low, so back-pressure travels upstream with no loss. The mark vector, enable bit and select bit are plain control pins. They are captured on the accepted frame-start beat and govern every beat of that frame, so a frame is never partly substituted. The milliwatt phase steps once per frame, which means every marked slot in a frame carries the same tone byte.

Top module: `rx_code_subst`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: An accepted beat whose frame-captured enable is 1 and whose slot has its captured mark bit (bit index = `in_chan`) set leaves the block with its byte replaced.
- R3: When the frame-captured enable is 0, every beat leaves with its original byte, whatever the mark bits hold.
- R4: A beat on an unmarked slot leaves with its original byte and slot index, after the same one-cycle latency as a replaced beat.
- R5: With the captured select bit at 0, the replacement byte is 0x7F.
- R6: With the captured select bit at 1, the replacement byte is entry p of the sequence 0x1E, 0x0B, 0x0B, 0x1E, 0x9E, 0x8B, 0x8B, 0x9E. Here p is (number of frame-start beats accepted since reset, minus one) modulo 8, so the first frame uses 0x1E and the ninth frame wraps back to it.
- R7: Mark, enable and select are sampled only on an accepted beat with `in_fstart` high. Changes at any other time have no effect until the next frame-start beat.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_data`, `out_chan` and `out_valid` hold their values.
- R9: A beat whose slot index is 24 or more is passed through unchanged.
- R10: Beats accepted after reset but before the first frame-start beat are passed through unchanged.
- R11: The accepted beat appears on `out_valid`/`out_data` in the clock cycle after acceptance, with `out_chan` and `out_fstart` copied from the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept a beat |
| in_data | input | 8 | Received channel byte |
| in_chan | input | 5 | Slot index of the beat |
| in_fstart | input | 1 | Beat is the first of a frame |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | 8 | Byte after substitution |
| out_chan | output | 5 | Slot index of the output beat |
| out_fstart | output | 1 | Output beat is first of a frame |
| chan_mark | input | 24 | Per-slot substitution request, bit n for slot n |
| insert_en | input | 1 | Global substitution enable |
| code_sel | input | 1 | 0 selects idle byte, 1 selects milliwatt tone |

## Verification
The bench changes enable, select and marks in the middle of a frame. A design that used the live pins would substitute only the tail of that frame, or stop substituting partway through. It runs nine consecutive tone frames: an off-by-one phase would give the first frame 0x0B, and a missing wrap would show up on the ninth frame. It also sends beats before any frame start and on slot indices past 23, where a bad reset state or a stray mark lookup would corrupt bytes. Finally it stalls the output with data still arriving; a stage that lost or overwrote a beat would show the second byte too early.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int BYTE_W = 8;
  localparam int MW_LEN = 8;
  localparam int MW_PW  = $clog2(MW_LEN);
  localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'h7F;

  typedef struct packed {
    logic en;
    logic sel;
  } ctl_t;

  // one period of the milliwatt tone, u-law coded
  function automatic logic [BYTE_W-1:0] mw_byte(input logic [MW_PW-1:0] ph);
    logic [BYTE_W-1:0] b;
    case (ph[1:0])
      2'd0, 2'd3: b = 8'h1E;
      default:    b = 8'h0B;
    endcase
    // second half of the period is the negative lobe: sign bit set
    b[7] = ph[2];
    return b;
  endfunction
endpackage

// File: rtl/rcs_ctrl_snap.sv
module rcs_ctrl_snap
  import rcs_pkg::*;
#(
  parameter int NCHAN = 24,
  parameter int CHW   = $clog2(NCHAN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_acc,
  input  logic             beat_fstart,
  input  logic [CHW-1:0]   beat_chan,
  input  logic [NCHAN-1:0] mark_in,
  input  logic             en_in,
  input  logic             sel_in,
  output logic             do_repl,
  output logic             use_mw
);
  localparam int SLOTS = 1 << CHW;

  logic [NCHAN-1:0] mark_q;
  ctl_t             ctl_q;
  logic [NCHAN-1:0] mark_eff;
  ctl_t             ctl_eff;
  logic [SLOTS-1:0] mark_pad;
  logic             take;

  assign take = beat_acc && beat_fstart;

  // frame-start beat uses the live pins, later beats the held copy
  always_comb begin
    if (beat_fstart) begin
      mark_eff = mark_in;
      ctl_eff  = '{en: en_in, sel: sel_in};
    end else begin
      mark_eff = mark_q;
      ctl_eff  = ctl_q;
    end
    mark_pad = '0;
    mark_pad[NCHAN-1:0] = mark_eff;
  end

  assign do_repl = ctl_eff.en && mark_pad[beat_chan];
  assign use_mw  = ctl_eff.sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mark_q <= '0;
      ctl_q  <= '{en: 1'b0, sel: 1'b0};
    end else if (take) begin
      mark_q <= mark_in;
      ctl_q  <= '{en: en_in, sel: sel_in};
    end
  end

  // R7
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(mark_q) && $stable(ctl_q)));

  // R7
  snap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (mark_q == $past(mark_in) && ctl_q.en == $past(en_in)
              && ctl_q.sel == $past(sel_in)));
endmodule

// File: rtl/rcs_mw_seq.sv
module rcs_mw_seq
  import rcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_adv,
  output logic [BYTE_W-1:0] mw_code
);
  logic [MW_PW-1:0] phase_q;
  logic [MW_PW-1:0] phase_eff;

  // reset to the last phase so the first frame lands on phase 0
  assign phase_eff = frame_adv ? phase_q + 1'b1 : phase_q;
  assign mw_code   = mw_byte(phase_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= '1;
    else if (frame_adv) phase_q <= phase_q + 1'b1;
  end

  // R6
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_adv |=> phase_q == $past(phase_q) + 1'b1);

  // R6
  phase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_adv |=> $stable(phase_q));
endmodule

// File: rtl/rcs_sub_stage.sv
module rcs_sub_stage
  import rcs_pkg::*;
#(
  parameter int CHW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic [CHW-1:0]    in_chan,
  input  logic              in_fstart,
  input  logic              do_repl,
  input  logic              use_mw,
  input  logic [BYTE_W-1:0] mw_code,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic [CHW-1:0]    out_chan,
  output logic              out_fstart
);
  logic              acc;
  logic [BYTE_W-1:0] sub_byte;
  logic [BYTE_W-1:0] nxt_byte;

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;
  assign sub_byte = use_mw ? mw_code : IDLE_BYTE;
  assign nxt_byte = do_repl ? sub_byte : in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_chan   <= '0;
      out_fstart <= 1'b0;
    end else if (acc) begin
      out_valid  <= 1'b1;
      out_data   <= nxt_byte;
      out_chan   <= in_chan;
      out_fstart <= in_fstart;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan)));

  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R3
  pass_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !do_repl) |=> (out_valid && out_data == $past(in_data)));

  // R5
  idle_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && do_repl && !use_mw) |=> out_data == IDLE_BYTE);

  // R6
  tone_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && do_repl && use_mw) |=> out_data == $past(mw_code));

  // R11
  chan_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (out_chan == $past(in_chan) && out_fstart == $past(in_fstart)));
endmodule

// File: rtl/rx_code_subst.sv
module rx_code_subst
  import rcs_pkg::*;
#(
  parameter int NCHAN = 24,
  parameter int CHW   = $clog2(NCHAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic [CHW-1:0]    in_chan,
  input  logic              in_fstart,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic [CHW-1:0]    out_chan,
  output logic              out_fstart,
  input  logic [NCHAN-1:0]  chan_mark,
  input  logic              insert_en,
  input  logic              code_sel
);
  logic              acc;
  logic              do_repl;
  logic              use_mw;
  logic [BYTE_W-1:0] mw_code;

  assign acc = in_valid && in_ready;

  rcs_ctrl_snap #(.NCHAN(NCHAN), .CHW(CHW)) u_snap (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_acc   (acc),
    .beat_fstart(in_fstart),
    .beat_chan  (in_chan),
    .mark_in    (chan_mark),
    .en_in      (insert_en),
    .sel_in     (code_sel),
    .do_repl    (do_repl),
    .use_mw     (use_mw)
  );

  rcs_mw_seq u_mw (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_adv(acc && in_fstart),
    .mw_code  (mw_code)
  );

  rcs_sub_stage #(.CHW(CHW)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_chan   (in_chan),
    .in_fstart (in_fstart),
    .do_repl   (do_repl),
    .use_mw    (use_mw),
    .mw_code   (mw_code),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_chan  (out_chan),
    .out_fstart(out_fstart)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && in_ready));
endmodule

// File: tb/rx_code_subst_bench.sv
module rx_code_subst_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_data;
  logic [4:0]  in_chan;
  logic        in_fstart;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  out_data;
  logic [4:0]  out_chan;
  logic        out_fstart;
  logic [23:0] chan_mark;
  logic        insert_en;
  logic        code_sel;

  int checks = 0;
  int errors = 0;

  // reference model state, updated only from the requirements
  logic [23:0] m_mark = '0;
  logic        m_en   = 1'b0;
  logic        m_sel  = 1'b0;
  int          m_frames = 0;

  always #5 clk = ~clk;

  rx_code_subst u_rx_code_subst (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_chan(in_chan), .in_fstart(in_fstart),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_chan(out_chan), .out_fstart(out_fstart), .chan_mark(chan_mark),
    .insert_en(insert_en), .code_sel(code_sel)
  );

  function automatic logic [7:0] tone(input int p);
    case (p % 8)
      0: return 8'h1E;  1: return 8'h0B;  2: return 8'h0B;  3: return 8'h1E;
      4: return 8'h9E;  5: return 8'h8B;  6: return 8'h8B;  default: return 8'h9E;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // entered and left at a falling edge
  task automatic send_beat(input int ch, input logic [7:0] d, input bit fs, input string tag);
    logic [7:0] exp;
    in_valid = 1'b1; in_chan = ch[4:0]; in_data = d; in_fstart = fs;
    if (fs) begin
      m_mark = chan_mark; m_en = insert_en; m_sel = code_sel; m_frames++;
    end
    if (ch < 24 && m_en && m_mark[ch]) exp = m_sel ? tone(m_frames - 1) : 8'h7F;
    else exp = d;
    @(posedge clk); @(negedge clk);
    check(out_valid == 1'b1, {tag, " (R11 valid)"}, out_valid, 1);
    check(out_data == exp, tag, out_data, exp);
    check(out_chan == ch[4:0] && out_fstart == fs, {tag, " (R11 chan)"}, out_chan, ch);
  endtask

  task automatic idle();
    in_valid = 1'b0; in_fstart = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
  endtask

  task automatic t_prefirst();
    chan_mark = '1; insert_en = 1'b1; code_sel = 1'b0;
    for (int c = 0; c < 4; c++) send_beat(c, 8'h40 + 8'(c), 1'b0, "R10 pre-frame pass");
    idle();
  endtask

  task automatic t_idle_frame();
    chan_mark = 24'hAAAAAA; insert_en = 1'b1; code_sel = 1'b0;
    for (int c = 0; c < 24; c++)
      send_beat(c, 8'(c * 7 + 3), c == 0, c[0] ? "R2 R5 marked idle" : "R4 unmarked pass");
    idle();
  endtask

  task automatic t_disabled();
    chan_mark = '1; insert_en = 1'b0; code_sel = 1'b1;
    for (int c = 0; c < 24; c++) send_beat(c, 8'(200 - c), c == 0, "R3 disabled pass");
  endtask

  task automatic t_tone();
    chan_mark = 24'h800001; insert_en = 1'b1; code_sel = 1'b1;
    for (int f = 0; f < 9; f++)
      for (int c = 0; c < 24; c++)
        send_beat(c, 8'(f * 16 + c), c == 0, "R6 tone sequence");
    idle();
  endtask

  task automatic t_midframe();
    chan_mark = '1; insert_en = 1'b1; code_sel = 1'b0;
    for (int c = 0; c < 24; c++) begin
      if (c == 10) begin chan_mark = 24'h0; insert_en = 1'b0; code_sel = 1'b1; end
      send_beat(c, 8'(c + 90), c == 0, "R7 mid-frame change ignored");
    end
    for (int c = 0; c < 24; c++) send_beat(c, 8'(c + 60), c == 0, "R7 change applied at frame start");
    idle();
  endtask

  task automatic t_highchan();
    chan_mark = '1; insert_en = 1'b1; code_sel = 1'b0;
    send_beat(0, 8'h11, 1'b1, "R2 slot 0 replaced");
    for (int c = 24; c < 32; c++) send_beat(c, 8'(c), 1'b0, "R9 slot past range");
    idle();
  endtask

  task automatic t_stall();
    logic [7:0] first;
    chan_mark = '0; insert_en = 1'b0; code_sel = 1'b0;
    out_ready = 1'b0;
    in_valid = 1'b1; in_chan = 5'd3; in_data = 8'hC3; in_fstart = 1'b1;
    @(posedge clk); @(negedge clk);
    first = out_data;
    check(out_valid && first == 8'hC3, "R8 stalled beat captured", first, 8'hC3);
    in_chan = 5'd4; in_data = 8'hD4; in_fstart = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); @(negedge clk);
      check(in_ready == 1'b0, "R8 in_ready low", in_ready, 0);
      check(out_valid && out_data == 8'hC3 && out_chan == 5'd3, "R8 output held", out_data, 8'hC3);
    end
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    check(out_valid && out_data == 8'hD4 && out_chan == 5'd4, "R8 next beat after release", out_data, 8'hD4);
    m_frames++;
    idle();
    check(out_valid == 1'b0, "R8 drains", out_valid, 0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_chan = '0; in_fstart = 1'b0;
    out_ready = 1'b1; chan_mark = '0; insert_en = 1'b0; code_sel = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prefirst();
    t_idle_frame();
    t_disabled();
    t_tone();
    t_midframe();
    t_highchan();
    t_stall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule